// File: doc/BRIEF.md
# Regulator Enable and Voltage-Code Selector

This block decides, for a single buck regulator channel, whether the regulator runs and which 8-bit output-voltage code it uses. Two control styles are available. In register control, a master enable bit turns the channel on at the normal code and the enable pins have no effect. In pin control, one of two external enable pins drives the channel. In enable mode the chosen pin switches the regulator on and off. In roof/floor mode the regulator stays on, and the pin chooses between the normal code and a lower floor code.

Changes driven by the chosen pin are delayed. A rising level is held back by a 4-bit startup setting and a falling level by a separate 4-bit shutdown setting. Each step of either setting lasts `TICKS_PER_STEP` clocks. A setting of zero means the change takes effect at the first clock edge that samples it. The level tracker is a four-state machine: `ST_OFF`, `ST_ARMING`, `ST_ON` and `ST_DISARMING`.

- `ST_OFF` goes to `ST_ON` when the pin is high and the startup setting is zero. It goes to `ST_ARMING` when the pin is high and the setting is nonzero, loading the counter with setting×`TICKS_PER_STEP`.
- `ST_ARMING` goes back to `ST_OFF` if the pin is low, which cancels the change. It goes to `ST_ON` when the counter expires.
- `ST_ON` and `ST_DISARMING` behave the same way for the falling direction, using the shutdown setting.

The tracker runs continuously on the selected pin level. The enable output is allowed only while the device reports its active-allowed (standby) state. The block also drives pull-down enables for the two pins. These are on after reset and are cleared by configuration bits.

Top module: `buck_vsel_ctrl`

## Requirements
- R1: When `mst_en` is 0, `reg_en` is 0 whatever the other inputs are.
- R2: When `dev_active` is 0, `reg_en` is 0 whatever the other inputs are.
- R3: When `mst_en`=1, `dev_active`=1 and `pin_ctl`=0, `reg_en` is 1 and `vcode_out` equals `vcode_norm`, and both pins are ignored.
- R4: In pin control, `pin_sel`=0 makes `en_pin1` the controlling pin and `pin_sel`=1 makes `en_pin2` the controlling pin. The other pin is ignored.
- R5: With `rf_mode`=0 in pin control, a low controlling level gives `reg_en`=0 and a high level gives `reg_en`=1 with `vcode_norm`. Whenever `reg_en`=0, `vcode_out` shows `vcode_norm`.
- R6: With `rf_mode`=1 in pin control (master on, device active), `reg_en` stays 1. A low controlling level selects `vcode_floor` and a high level selects `vcode_norm`.
- R7: A high controlling level sampled first at clock edge k takes effect at edge k+`up_dly`×`TICKS_PER_STEP`. With `up_dly`=0 it takes effect at edge k.
- R8: A low controlling level sampled first at edge k takes effect at edge k+`dn_dly`×`TICKS_PER_STEP`. With `dn_dly`=0 it takes effect at edge k.
- R9: If the controlling level returns to its old value before a delay expires, the pending change is dropped. A later edge restarts the full delay.
- R10: Changes of `mst_en` or `pin_ctl` act without any startup or shutdown delay.
- R11: During and after reset `pd_en` is 2'b11. One clock edge after `pd_dis[i]` is sampled, `pd_en[i]` equals its inverse.
- R12: In roof/floor mode the switch between the floor and normal codes obeys the same startup and shutdown delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_active | input | 1 | Device is in its active-allowed state |
| mst_en | input | 1 | Master enable bit |
| pin_ctl | input | 1 | 1: pin control, 0: register control |
| pin_sel | input | 1 | 0: en_pin1 controls, 1: en_pin2 controls |
| rf_mode | input | 1 | 1: roof/floor voltage switching |
| en_pin1 | input | 1 | Enable pin 1, already synchronised |
| en_pin2 | input | 1 | Enable pin 2, already synchronised |
| up_dly | input | DLY_W | Startup delay steps |
| dn_dly | input | DLY_W | Shutdown delay steps |
| vcode_norm | input | VCODE_W | Normal voltage code |
| vcode_floor | input | VCODE_W | Floor voltage code |
| pd_dis | input | 2 | Pull-down disable per pin |
| reg_en | output | 1 | Regulator enable |
| vcode_out | output | VCODE_W | Selected voltage code |
| pd_en | output | 2 | Pull-down enable per pin |

## Verification
The bench measures the startup and shutdown delays to the exact edge. An off-by-one counter load would switch one cycle early or late, and a swapped delay field would give the wrong length in one direction. It cancels a pending startup mid-count and then checks that a new edge waits the full delay again. A design that forgot to cancel would switch on anyway, and one that resumed the old count would switch early.

Truth-table vectors cover every pin-select and roof/floor combination, so a swapped pin mux or an inverted floor choice shows up as a wrong enable or code. Toggling the master bit while long delays are programmed catches a design that wrongly delays register-driven changes.

// File: rtl/buck_vsel_pkg.sv
package buck_vsel_pkg;

    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_ARMING    = 2'd1,
        ST_ON        = 2'd2,
        ST_DISARMING = 2'd3
    } trk_state_t;

endpackage

// File: rtl/buck_pin_pick.sv
module buck_pin_pick (
    input  logic pin_sel,
    input  logic en_pin1,
    input  logic en_pin2,
    output logic sel_lvl
);
    always_comb begin
        sel_lvl = pin_sel ? en_pin2 : en_pin1;
    end
endmodule

// File: rtl/buck_edge_delay.sv
module buck_edge_delay
    import buck_vsel_pkg::*;
#(
    parameter int DLY_W          = 4,
    parameter int TICKS_PER_STEP = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_lvl,
    input  logic [DLY_W-1:0] up_dly,
    input  logic [DLY_W-1:0] dn_dly,
    output logic             trk_on
);
    localparam int MAX_CNT = ((1 << DLY_W) - 1) * TICKS_PER_STEP;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    trk_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] up_len, dn_len;

    always_comb begin
        up_len = CNT_W'(up_dly) * CNT_W'(TICKS_PER_STEP);
        dn_len = CNT_W'(dn_dly) * CNT_W'(TICKS_PER_STEP);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                if (sel_lvl) begin
                    if (up_dly == '0) begin
                        state_d = ST_ON;
                    end else begin
                        state_d = ST_ARMING;
                        cnt_d   = up_len;
                    end
                end
            end
            ST_ARMING: begin
                if (!sel_lvl) begin
                    state_d = ST_OFF;
                end else if (cnt_q == CNT_W'(1)) begin
                    state_d = ST_ON;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_ON: begin
                if (!sel_lvl) begin
                    if (dn_dly == '0) begin
                        state_d = ST_OFF;
                    end else begin
                        state_d = ST_DISARMING;
                        cnt_d   = dn_len;
                    end
                end
            end
            ST_DISARMING: begin
                if (sel_lvl) begin
                    state_d = ST_ON;
                end else if (cnt_q == CNT_W'(1)) begin
                    state_d = ST_OFF;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // output logic
    always_comb begin
        trk_on = (state_q == ST_ON) || (state_q == ST_DISARMING);
    end
endmodule

// File: rtl/buck_vsel_ctrl.sv
module buck_vsel_ctrl #(
    parameter int VCODE_W        = 8,
    parameter int DLY_W          = 4,
    parameter int TICKS_PER_STEP = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dev_active,
    input  logic               mst_en,
    input  logic               pin_ctl,
    input  logic               pin_sel,
    input  logic               rf_mode,
    input  logic               en_pin1,
    input  logic               en_pin2,
    input  logic [DLY_W-1:0]   up_dly,
    input  logic [DLY_W-1:0]   dn_dly,
    input  logic [VCODE_W-1:0] vcode_norm,
    input  logic [VCODE_W-1:0] vcode_floor,
    input  logic [1:0]         pd_dis,
    output logic               reg_en,
    output logic [VCODE_W-1:0] vcode_out,
    output logic [1:0]         pd_en
);
    logic sel_lvl;
    logic trk_on;
    logic use_floor;

    buck_pin_pick u_pick (
        .pin_sel (pin_sel),
        .en_pin1 (en_pin1),
        .en_pin2 (en_pin2),
        .sel_lvl (sel_lvl)
    );

    buck_edge_delay #(
        .DLY_W          (DLY_W),
        .TICKS_PER_STEP (TICKS_PER_STEP)
    ) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_lvl (sel_lvl),
        .up_dly  (up_dly),
        .dn_dly  (dn_dly),
        .trk_on  (trk_on)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_en <= 2'b11;
        end else begin
            pd_en <= ~pd_dis;
        end
    end

    // outputs
    always_comb begin
        reg_en    = dev_active && mst_en && (!pin_ctl || rf_mode || trk_on);
        use_floor = reg_en && pin_ctl && rf_mode && !trk_on;
        vcode_out = use_floor ? vcode_floor : vcode_norm;
    end
endmodule

// File: rtl/buck_vsel_ctrl_chk.sv
module buck_vsel_ctrl_chk #(
    parameter int VCODE_W = 8,
    parameter int DLY_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dev_active,
    input logic               mst_en,
    input logic               pin_ctl,
    input logic               pin_sel,
    input logic               rf_mode,
    input logic               en_pin1,
    input logic               en_pin2,
    input logic [DLY_W-1:0]   up_dly,
    input logic [DLY_W-1:0]   dn_dly,
    input logic [VCODE_W-1:0] vcode_norm,
    input logic [VCODE_W-1:0] vcode_floor,
    input logic [1:0]         pd_dis,
    input logic               reg_en,
    input logic [VCODE_W-1:0] vcode_out,
    input logic [1:0]         pd_en
);
    logic chk_lvl;
    logic cfg_hold;
    always_comb begin
        chk_lvl = pin_sel ? en_pin2 : en_pin1;
    end

    assign cfg_hold = 1'b1;

    AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !mst_en |-> !reg_en); // R1

    AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_active |-> !reg_en); // R2

    AST_REG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_en && dev_active && !pin_ctl) |-> (reg_en && vcode_out == vcode_norm)); // R3

    AST_RF_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_en && dev_active && pin_ctl && rf_mode) |-> reg_en); // R6

    AST_PD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hold |=> (pd_en == ~$past(pd_dis))); // R11

    AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(chk_lvl) && up_dly != '0 && mst_en && dev_active && pin_ctl && !rf_mode && !reg_en)
        |=> (!reg_en || !$stable(pin_ctl) || !$stable(rf_mode) || !$stable(mst_en) || !$stable(dev_active))); // R7

    AST_NO_EARLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(chk_lvl) && dn_dly != '0 && mst_en && dev_active && pin_ctl && !rf_mode && reg_en)
        |=> (reg_en || !$stable(pin_ctl) || !$stable(rf_mode) || !$stable(mst_en) || !$stable(dev_active))); // R8
endmodule

bind buck_vsel_ctrl buck_vsel_ctrl_chk #(
    .VCODE_W (VCODE_W),
    .DLY_W   (DLY_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_active  (dev_active),
    .mst_en      (mst_en),
    .pin_ctl     (pin_ctl),
    .pin_sel     (pin_sel),
    .rf_mode     (rf_mode),
    .en_pin1     (en_pin1),
    .en_pin2     (en_pin2),
    .up_dly      (up_dly),
    .dn_dly      (dn_dly),
    .vcode_norm  (vcode_norm),
    .vcode_floor (vcode_floor),
    .pd_dis      (pd_dis),
    .reg_en      (reg_en),
    .vcode_out   (vcode_out),
    .pd_en       (pd_en)
);

// File: tb/buck_vsel_ctrl_tb_top.sv
module buck_vsel_ctrl_tb_top;
    localparam int TPS = 3;
    localparam logic [7:0] NORM  = 8'hA5;
    localparam logic [7:0] FLOOR = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_active = 1'b0, mst_en = 1'b0, pin_ctl = 1'b0, pin_sel = 1'b0, rf_mode = 1'b0;
    logic       en_pin1 = 1'b0, en_pin2 = 1'b0;
    logic [3:0] up_dly = '0, dn_dly = '0;
    logic [7:0] vcode_norm = NORM, vcode_floor = FLOOR;
    logic [1:0] pd_dis = 2'b11;
    logic       reg_en;
    logic [7:0] vcode_out;
    logic [1:0] pd_en;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    buck_vsel_ctrl #(.VCODE_W(8), .DLY_W(4), .TICKS_PER_STEP(TPS)) dut_i (
        .clk(clk), .rst_n(rst_n), .dev_active(dev_active), .mst_en(mst_en),
        .pin_ctl(pin_ctl), .pin_sel(pin_sel), .rf_mode(rf_mode),
        .en_pin1(en_pin1), .en_pin2(en_pin2), .up_dly(up_dly), .dn_dly(dn_dly),
        .vcode_norm(vcode_norm), .vcode_floor(vcode_floor), .pd_dis(pd_dis),
        .reg_en(reg_en), .vcode_out(vcode_out), .pd_en(pd_en)
    );

    // {mst, dev, pinctl, sel, rf, en1, en2, exp_en, exp_floor}
    localparam int NV = 14;
    localparam logic [8:0] VEC [NV] = '{
        9'b0_1_0_0_0_1_1_0_0,  // R1
        9'b0_1_1_0_1_0_0_0_0,  // R1
        9'b1_0_0_0_0_1_1_0_0,  // R2
        9'b1_1_0_0_0_0_0_1_0,  // R3
        9'b1_1_0_0_0_1_0_1_0,  // R3
        9'b1_1_1_0_0_0_1_0_0,  // R4 R5
        9'b1_1_1_0_0_1_0_1_0,  // R5
        9'b1_1_1_1_0_1_0_0_0,  // R4
        9'b1_1_1_1_0_0_1_1_0,  // R4
        9'b1_1_1_0_1_0_1_1_1,  // R6
        9'b1_1_1_0_1_1_0_1_0,  // R6
        9'b1_1_1_1_1_1_0_1_1,  // R6
        9'b1_1_1_1_1_0_1_1_0,  // R6
        9'b1_0_1_1_1_0_1_0_0   // R2
    };
    localparam string VTAG [NV] = '{"R1","R1","R2","R3","R3","R4","R5","R4","R4",
                                    "R6","R6","R6","R6","R2"};

    task automatic check(input string tag, input logic exp_en, input logic [7:0] exp_code);
        n_checks++;
        if (reg_en !== exp_en || vcode_out !== exp_code) begin
            n_errs++;
            $display("FAIL %s: reg_en=%0b vcode=%h expected reg_en=%0b vcode=%h",
                     tag, reg_en, vcode_out, exp_en, exp_code);
        end
    endtask

    task automatic check_pd(input string tag, input logic [1:0] exp);
        n_checks++;
        if (pd_en !== exp) begin
            n_errs++;
            $display("FAIL %s: pd_en=%b expected %b", tag, pd_en, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        // reset state: R11
        edges(3);
        check_pd("R11 reset", 2'b11);
        check("R1 reset", 1'b0, NORM);
        rst_n = 1'b1;
        edges(1);
        check_pd("R11 disable both", 2'b00);
        pd_dis = 2'b01;
        edges(1);
        check_pd("R11 disable pin1 only", 2'b10);

        // truth table, zero delays
        for (int i = 0; i < NV; i++) begin
            {mst_en, dev_active, pin_ctl, pin_sel, rf_mode, en_pin1, en_pin2} = VEC[i][8:2];
            edges(1);
            check(VTAG[i], VEC[i][1], VEC[i][0] ? FLOOR : NORM);
        end

        // R7 startup delay: 2 steps * 3 ticks = 6 edges
        {mst_en, dev_active, pin_ctl, pin_sel, rf_mode, en_pin1, en_pin2} = 7'b1_1_1_0_0_0_0;
        up_dly = 4'd2; dn_dly = 4'd1;
        edges(60);
        check("R5 settle off", 1'b0, NORM);
        en_pin1 = 1'b1;
        edges(6);
        check("R7 not yet on", 1'b0, NORM);
        edges(1);
        check("R7 on at delay", 1'b1, NORM);

        // R8 shutdown delay: 1 step = 3 edges
        en_pin1 = 1'b0;
        edges(3);
        check("R8 still on", 1'b1, NORM);
        edges(1);
        check("R8 off at delay", 1'b0, NORM);

        // R9 cancel and restart
        en_pin1 = 1'b1;
        edges(3);
        en_pin1 = 1'b0;
        edges(10);
        check("R9 cancelled start", 1'b0, NORM);
        en_pin1 = 1'b1;
        edges(6);
        check("R9 full delay restarts", 1'b0, NORM);
        edges(1);
        check("R9 on after restart", 1'b1, NORM);

        // R10 register-driven changes are immediate despite delays
        pin_ctl = 1'b0; mst_en = 1'b0; en_pin1 = 1'b0;
        edges(1);
        check("R10 master off immediate", 1'b0, NORM);
        mst_en = 1'b1;
        edges(1);
        check("R10 master on immediate", 1'b1, NORM);

        // R12 roof/floor switching with delays
        pin_ctl = 1'b1; rf_mode = 1'b1; en_pin1 = 1'b1;
        edges(60);
        check("R6 settle normal", 1'b1, NORM);
        en_pin1 = 1'b0;
        edges(3);
        check("R12 floor delayed", 1'b1, NORM);
        edges(1);
        check("R12 floor reached", 1'b1, FLOOR);
        en_pin1 = 1'b1;
        edges(6);
        check("R12 normal delayed", 1'b1, FLOOR);
        edges(1);
        check("R12 normal reached", 1'b1, NORM);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule